// File: doc/BRIEF.md
# Timer with Shared Prescaler

An 8-bit timer/counter whose single prescaler is switched between the timer itself and a watchdog tick path. The count source is either a one-cycle-wide enable that marks the internal instruction rate, or an external pin. The pin is brought into the system clock through a synchronizer, and either its rising or its falling edge is counted. A 3-bit rate code sets the prescaler ratio. That ratio runs one power of two higher when the prescaler serves the timer (1:2 to 1:256) than when it serves the watchdog (1:1 to 1:128).

Software reaches three registers through a simple write strobe with a combinational read port: the count, the control register and an interrupt control register. Rolling the count from 0xFF to 0x00 sets a sticky overflow flag. The flag, qualified by its enable, drives the interrupt output. The watchdog counter itself is not part of this block. Only its prescaled tick, `wdt_tick`, leaves it.

Top module: `ptmr_top`

## Requirements
- R1: After reset the control register reads 0x3F and the interrupt control register reads 0x00. Control layout: bit0 `src_ext`, bit1 `edge_fall`, bit2 `to_wdt`, bits5:3 `rate`, bits7:6 read 0. Interrupt control layout: bit0 enable, bit1 overflow flag. The count register is not cleared by reset.
- R2: Address 0 selects the count register, 1 the control register and 2 the interrupt control register. Address 3 reads 0. Reads are combinational, and a write with `bus_wr` high takes effect at the next clock edge.
- R3: With `src_ext`=0, every cycle with `inst_en` high is a source event, and the pin is ignored.
- R4: With `src_ext`=1, the pin passes through two synchronizer flops before edge detection. A rising edge is counted when `edge_fall`=0 and a falling edge when `edge_fall`=1, one event per edge. `inst_en` is ignored in this mode.
- R5: With `to_wdt`=0, the timer advances once per 2^(rate+1) source events.
- R6: With `to_wdt`=1, the timer advances on every source event, and `wdt_tick` pulses on one `wdt_src` cycle in every 2^rate. With `to_wdt`=0, `wdt_tick` equals `wdt_src`.
- R7: A write to the count register loads it and clears the prescaler counter, and the rate code is left unchanged.
- R8: A timer advance from 0xFF to 0x00 sets the overflow flag. The flag stays set until a write to the interrupt control register puts 0 in bit1. A hardware set in the same cycle wins over that write.
- R9: `irq` is high exactly when both the enable bit and the flag are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inst_en | input | 1 | Internal instruction-rate enable, one cycle per event |
| ext_pin | input | 1 | External count pin, asynchronous |
| wdt_src | input | 1 | Watchdog base tick, one cycle per event |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Overflow interrupt |
| wdt_tick | output | 1 | Prescaled tick toward the watchdog |

## Verification
A wrong prescaler phase shows up as the count register advancing one or more source events early or late. The read port exposes this in the cycle after the offending edge, and `wdt_tick` exposes it on the same cycle as the `wdt_src` pulse. A synchronizer that is off by one stage delays or duplicates the count by a cycle relative to a pin edge, and a per-clock comparison catches that at once. A flag that is cleared or set wrongly changes `irq` and the interrupt register reads in the cycle right after the overflow or the write.

// File: rtl/ptmr_pkg.sv
// Shared types for the shared-prescaler timer.
// Assumes an 8-bit register bus with a 2-bit address.
package ptmr_pkg;
    typedef enum logic [1:0] {
        A_COUNT = 2'd0,
        A_CTRL  = 2'd1,
        A_INTC  = 2'd2,
        A_NONE  = 2'd3
    } reg_addr_e;

    // Control register fields, LSB first: src_ext, edge_fall, to_wdt, rate
    typedef struct packed {
        logic [2:0] rate;
        logic       to_wdt;
        logic       edge_fall;
        logic       src_ext;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/ptmr_edge_sync.sv
// Brings an asynchronous pin into clk through STAGES flops, then flags
// one cycle per selected edge (rising when edge_fall=0, falling when 1).
// Assumes STAGES >= 2.
module ptmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_fall,
    output logic edge_ev
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              level;

    assign level = sync_q[STAGES-1];

    // Synchronizer chain and previous-level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= level;
        end
    end

    // Edge selection
    always_comb begin
        edge_ev = edge_fall ? (prev_q & ~level) : (level & ~prev_q);
    end
endmodule

// File: rtl/ptmr_prescaler.sv
// Shared prescaler counter. When to_wdt=0 it divides timer events by
// 2^(rate+1); when to_wdt=1 it divides watchdog events by 2^rate and
// timer events pass through. clr resets the counter phase.
// Assumes 2^(2^RATE_W) <= 2^PRE_W.
module ptmr_prescaler #(
    parameter int PRE_W  = 8,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    input  logic              tmr_ev,
    input  logic              wdt_ev,
    output logic              tmr_tick,
    output logic              wdt_tick
);
    localparam logic [PRE_W:0] ONE = {{PRE_W{1'b0}}, 1'b1};

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W:0]   tmask;
    logic [PRE_W:0]   wmask;
    logic             inc;
    logic             t_full;
    logic             w_full;

    // Ratio masks: timer one step above watchdog
    always_comb begin
        tmask  = (ONE << ((RATE_W+1)'(rate) + (RATE_W+1)'(1))) - ONE;
        wmask  = (ONE << rate) - ONE;
        t_full = (({1'b0, cnt_q} & tmask) == tmask);
        w_full = (({1'b0, cnt_q} & wmask) == wmask);
        inc    = to_wdt ? wdt_ev : tmr_ev;
    end

    // Prescaler counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick outputs per assignment
    always_comb begin
        tmr_tick = to_wdt ? tmr_ev : (tmr_ev & t_full);
        wdt_tick = to_wdt ? (wdt_ev & w_full) : wdt_ev;
    end
endmodule

// File: rtl/ptmr_counter.sv
// Count register with overflow flag and interrupt enable. The count
// holds through reset; the flag and enable clear on reset. A hardware
// overflow wins over a software write of the flag in the same cycle.
module ptmr_counter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_cnt,
    input  logic              wr_int,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] count,
    output logic              flag,
    output logic              ie
);
    logic ovf;

    assign ovf = tick & ~wr_cnt & (&count);

    // Count register, kept across reset
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (wr_cnt) begin
                count <= wr_data;
            end else if (tick) begin
                count <= count + 1'b1;
            end
        end
    end

    // Flag and enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            flag <= 1'b0;
        end else if (wr_int) begin
            ie   <= wr_data[0];
            flag <= wr_data[1] | ovf;
        end else if (ovf) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_top.sv
// Shared-prescaler timer top: register port, source select, prescaler
// routing and interrupt. inst_en and wdt_src are single-cycle enables
// in clk; ext_pin is asynchronous.
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inst_en,
    input  logic              ext_pin,
    input  logic              wdt_src,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdt_tick
);
    ctl_t              ctl_q;
    logic              ext_ev;
    logic              src_ev;
    logic              tmr_tick;
    logic              wr_cnt;
    logic              wr_ctl;
    logic              wr_int;
    logic [DATA_W-1:0] count;
    logic              flag;
    logic              ie;

    // Write decode
    always_comb begin
        wr_cnt = bus_wr && (bus_addr == A_COUNT);
        wr_ctl = bus_wr && (bus_addr == A_CTRL);
        wr_int = bus_wr && (bus_addr == A_INTC);
    end

    // Control register, all fields set on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '1;
        end else if (wr_ctl) begin
            ctl_q <= ctl_t'(bus_wdata[CTL_W-1:0]);
        end
    end

    ptmr_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_pin),
        .edge_fall (ctl_q.edge_fall),
        .edge_ev   (ext_ev)
    );

    // Source select
    assign src_ev = ctl_q.src_ext ? ext_ev : inst_en;

    ptmr_prescaler #(.PRE_W(PRE_W), .RATE_W(3)) pre_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr_cnt),
        .to_wdt   (ctl_q.to_wdt),
        .rate     (ctl_q.rate),
        .tmr_ev   (src_ev),
        .wdt_ev   (wdt_src),
        .tmr_tick (tmr_tick),
        .wdt_tick (wdt_tick)
    );

    ptmr_counter #(.DATA_W(DATA_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tmr_tick),
        .wr_cnt  (wr_cnt),
        .wr_int  (wr_int),
        .wr_data (bus_wdata),
        .count   (count),
        .flag    (flag),
        .ie      (ie)
    );

    assign irq = flag & ie;

    // Combinational read mux
    always_comb begin
        case (bus_addr)
            A_COUNT: bus_rdata = count;
            A_CTRL:  bus_rdata = DATA_W'(ctl_q);
            A_INTC:  bus_rdata = DATA_W'({flag, ie});
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ptmr_chk.sv
// Property checker for ptmr_top, attached by bind below.
module ptmr_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              wdt_src,
    input logic              wdt_tick,
    input logic              ext_ev,
    input logic [DATA_W-1:0] count,
    input logic              flag
);
    logic wr_cnt;
    logic wr_int;
    assign wr_cnt = bus_wr && (bus_addr == 2'd0);
    assign wr_int = bus_wr && (bus_addr == 2'd2);

    // R7: without a count write the count moves only by +1
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_cnt) && (count != $past(count)))
        |-> (count == DATA_W'($past(count) + 1'b1)));

    // R8: flag set by hardware only on a roll to zero
    p_ovf_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flag) && flag && !$past(wr_int))
        |-> (count == '0));

    // R8: flag sticky without a write
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag) && !$past(wr_int)) |-> flag);

    // R6: no watchdog tick without a base tick
    p_wdt_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tick |-> wdt_src);

    // R4: one event per edge, never two in a row
    p_one_per_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ev |=> !ext_ev);
endmodule

bind ptmr_top ptmr_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wdt_src  (wdt_src),
    .wdt_tick (wdt_tick),
    .ext_ev   (ext_ev),
    .count    (count),
    .flag     (flag)
);

// File: tb/ptmr_top_tb_top.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks with hand-computed values.
module ptmr_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inst_en = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wdt_src = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       wdt_tick;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    int wt_cnt = 0;

    // model state
    int m_ctl = 8'h3F, m_ie = 0, m_if = 0, m_cnt = 0, m_pre = 0;
    bit m_known = 0;
    bit m_s1 = 0, m_s2 = 0, m_s3 = 0;

    ptmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .inst_en(inst_en), .ext_pin(ext_pin),
        .wdt_src(wdt_src), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .wdt_tick(wdt_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
        end
    endtask

    // reference model update, one step per rising edge
    always @(posedge clk) begin
        int rate, ev, tick, ovf, pw;
        bit eev, wrc, wri, wrl;
        if (!rst_n) begin
            m_ctl = 8'h3F; m_ie = 0; m_if = 0; m_pre = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            rate = (m_ctl >> 3) & 7;
            eev = ((m_ctl >> 1) & 1) ? (m_s3 && !m_s2) : (m_s2 && !m_s3);
            ev = (m_ctl & 1) ? int'(eev) : int'(inst_en);
            wrc = bus_wr && bus_addr == 0;
            wrl = bus_wr && bus_addr == 1;
            wri = bus_wr && bus_addr == 2;
            tick = 0;
            if ((m_ctl >> 2) & 1) begin
                tick = ev;
            end else if (ev != 0) begin
                pw = 2 << rate;
                tick = (((m_pre + 1) % pw) == 0) ? 1 : 0;
            end
            ovf = (tick != 0 && !wrc && m_cnt == 255) ? 1 : 0;
            if (wrc) begin
                m_cnt = bus_wdata; m_known = 1; m_pre = 0;
            end else begin
                if (tick != 0) m_cnt = (m_cnt + 1) % 256;
                if ((m_ctl >> 2) & 1) begin
                    if (wdt_src) m_pre = (m_pre + 1) % 256;
                end else if (ev != 0) begin
                    m_pre = (m_pre + 1) % 256;
                end
            end
            if (wri) begin
                m_ie = bus_wdata[0]; m_if = bus_wdata[1] | ovf;
            end else if (ovf != 0) begin
                m_if = 1;
            end
            if (wrl) m_ctl = bus_wdata & 8'h3F;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
        end
    end

    // per-cycle comparison, before inputs move
    always @(negedge clk) begin
        int exp_rd, exp_wt, rate;
        cycles++;
        if (wdt_tick) wt_cnt++;
        if (rst_n) begin
            rate = (m_ctl >> 3) & 7;
            if ((m_ctl >> 2) & 1)
                exp_wt = (wdt_src && (((m_pre + 1) % (1 << rate)) == 0)) ? 1 : 0;
            else
                exp_wt = int'(wdt_src);
            chk("R6 wdt_tick", int'(wdt_tick), exp_wt);
            chk("R9 irq", int'(irq), m_ie & m_if);
            case (bus_addr)
                2'd0: exp_rd = m_cnt;
                2'd1: exp_rd = m_ctl;
                2'd2: exp_rd = (m_if << 1) | m_ie;
                default: exp_rd = 0;
            endcase
            if (bus_addr != 2'd0 || m_known)
                chk("R2 rdata", int'(bus_rdata), exp_rd);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step(); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input int exp);
        step(); bus_addr = a; #1;
        chk(req, int'(bus_rdata), exp);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            step(); inst_en = 1'b1;
            step(); inst_en = 1'b0;
        end
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            step(); ext_pin = 1'b1;
            repeat (4) step();
            ext_pin = 1'b0;
            repeat (4) step();
        end
    endtask

    task automatic wsrc(input int n);
        for (int i = 0; i < n; i++) begin
            step(); wdt_src = 1'b1;
        end
        step(); wdt_src = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL all watchdog expired");
            finish_run();
        end
    end

    initial begin
        int w0;
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset values
        rd(2'd1, "R1 ctl reset", 8'h3F);
        rd(2'd2, "R1 intc reset", 0);
        chk("R9 irq reset", int'(irq), 0);
        // R2 map
        wr(2'd0, 8'h12);
        rd(2'd0, "R2 count read", 8'h12);
        rd(2'd3, "R2 addr3 zero", 0);
        // R3 R5 internal, rate 0 (1:2)
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
        pulses(10);
        rd(2'd0, "R3 R5 ratio 2", 5);
        // R5 rate 2 (1:8)
        wr(2'd1, 8'h10); wr(2'd0, 8'h00);
        pulses(16);
        rd(2'd0, "R5 ratio 8", 2);
        // R6 timer undivided
        wr(2'd1, 8'h04); wr(2'd0, 8'h00);
        pulses(7);
        rd(2'd0, "R6 direct count", 7);
        // R4 external rising, inst_en ignored
        wr(2'd1, 8'h05); wr(2'd0, 8'h00);
        inst_en = 1'b1;
        pin_pulses(3);
        inst_en = 1'b0;
        rd(2'd0, "R4 rising edges", 3);
        // R4 falling
        wr(2'd1, 8'h07); wr(2'd0, 8'h00);
        pin_pulses(3);
        rd(2'd0, "R4 falling edges", 3);
        // R8 R9 overflow
        wr(2'd1, 8'h04); wr(2'd2, 8'h01); wr(2'd0, 8'hFE);
        pulses(2);
        rd(2'd0, "R8 wrap to 0", 0);
        rd(2'd2, "R8 flag set", 3);
        chk("R9 irq high", int'(irq), 1);
        pulses(1);
        rd(2'd2, "R8 flag sticky", 3);
        wr(2'd2, 8'h01);
        rd(2'd2, "R8 flag cleared", 1);
        chk("R9 irq low after clear", int'(irq), 0);
        wr(2'd0, 8'hFF); pulses(1);
        wr(2'd2, 8'h02);
        chk("R9 irq masked", int'(irq), 0);
        wr(2'd2, 8'h00);
        // R6 watchdog ratio 8 and pass-through
        wr(2'd1, 8'h1C); wr(2'd0, 8'h00);
        w0 = wt_cnt; wsrc(24);
        chk("R6 wdt ratio 8", wt_cnt - w0, 3);
        wr(2'd1, 8'h18);
        w0 = wt_cnt; wsrc(5);
        chk("R6 wdt pass", wt_cnt - w0, 5);
        // R7 count write clears prescaler, rate kept
        wr(2'd1, 8'h08); wr(2'd0, 8'h00);
        pulses(3);
        wr(2'd0, 8'h40);
        pulses(3);
        rd(2'd0, "R7 phase cleared", 8'h40);
        pulses(1);
        rd(2'd0, "R7 tick after 4", 8'h41);
        rd(2'd1, "R7 rate kept", 8'h08);
        // random traffic, model compared each cycle
        for (int i = 0; i < 4000; i++) begin
            step();
            inst_en = ($urandom % 3) == 0;
            wdt_src = ($urandom % 3) == 0;
            if (($urandom % 5) == 0) ext_pin = ~ext_pin;
            bus_addr = 2'($urandom % 4);
            bus_wr = ($urandom % 20) == 0;
            bus_wdata = 8'($urandom);
            if (bus_wr && bus_addr == 2'd0 && ($urandom % 2) == 0) bus_wdata = 8'hFD;
            if (bus_wr && bus_addr == 2'd1) bus_wdata[5:3] = 3'($urandom % 3);
        end
        step(); bus_wr = 1'b0;
        // R1 reset again: count kept
        step(); rst_n = 1'b0;
        step(); rst_n = 1'b1;
        rd(2'd1, "R1 ctl after reset", 8'h3F);
        rd(2'd0, "R1 count kept", m_cnt);
        repeat (2) step();
        finish_run();
    end
endmodule